// File: doc/BRIEF.md
# Byte-serial TFT sync timing generator

This block produces the line sync, frame sync and data-enable window for a 320x240 TFT panel. The panel's pixel data arrives over an 8-bit byte-serial bus, so each pixel takes several bus clock ticks. All timing is counted in those ticks. A mode input selects 16-bit colour, at 2 ticks per pixel, or 24-bit colour, at 3 ticks per pixel. Every horizontal timing scales with that factor.

The start of the data window is pushed later by a short pipeline delay that depends on the mode. This lines the window up with the byte formatter that sits downstream. The four blanking lines of a frame are split evenly, with half above the active rows and half below them. The mode is picked up only at a frame boundary, so a frame is never built from two geometries. The current line and tick counters are exported so the pixel fetch logic can follow the raster.

Top module: `lcd_sync_gen`

## Requirements
- R1: While reset is asserted or `en_i` is low, both syncs are high (inactive) and `de_o` is low. On the next clock edge both counters clear to zero. The first enabled cycle shows tick 0 of line 0.
- R2: `mode_i` = 0 selects 2 ticks per pixel (16-bit colour) and `mode_i` = 1 selects 3 ticks per pixel (24-bit colour). Every horizontal timing below is in pixel times multiplied by that factor.
- R3: A line lasts `H_TOTAL_PIX` (336) pixel times. `tick_o` counts 0 up to 336*tpp-1, then wraps to 0, and `line_o` advances on that wrap.
- R4: A frame holds `V_ACT` + `V_BLANK` lines (240 + 4 = 244). `line_o` wraps from 243 back to 0 at the end of the last tick of the last line.
- R5: `hs_n_o` is low on ticks 0 to 2*tpp-1 of every line, and high on every other tick.
- R6: `vs_n_o` is low on ticks 0 to 2*tpp-1 of line 0 only, and high on every other tick of the frame.
- R7: On active lines, `de_o` is high for exactly 320*tpp consecutive ticks. The first of these ticks is 7*tpp + d, where d is 3 in 16-bit mode and 5 in 24-bit mode.
- R8: Active lines are lines `V_BLANK/2` through `V_BLANK/2 + V_ACT - 1` (lines 2 to 241). `de_o` stays low on every other line.
- R9: A change of `mode_i` while enabled takes effect only when the frame ends, or on reset or disable. The running frame keeps its old geometry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus tick clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Run the raster. Low holds the counters at zero |
| mode_i | input | 1 | 0: 2 ticks/pixel, 1: 3 ticks/pixel |
| hs_n_o | output | 1 | Line sync, active low |
| vs_n_o | output | 1 | Frame sync, active low |
| de_o | output | 1 | Data-enable window |
| line_o | output | V_W (8) | Current line, 0 to 243 |
| tick_o | output | H_W (10) | Current tick within the line |

## Verification
The bench runs a shrunken geometry, with the same structure and the same pipeline delays, so that whole frames fit in both modes. It flips the mode in the middle of a frame. A design that switched at once would show a shorter or longer line before the frame ends, and the tick and enable mismatches would show it. The bench also drops the enable and applies reset in the middle of a line. A design that did not clear the counters, or that let a sync through while idle, would fail on the restart tick. The edges of the enable window and the first and last active rows are compared on every cycle. An off-by-one in the pipeline delay or in the blanking split shows up as an extra or missing enable tick.

// File: rtl/lcd_sync_pkg.sv
// Shared types and helpers for the TFT sync generator.
// Assumes exactly two colour modes, selected by a one-bit input.
package lcd_sync_pkg;

    typedef enum logic {
        MODE_RGB16 = 1'b0,
        MODE_RGB24 = 1'b1
    } pix_mode_e;

    localparam int unsigned MODE_COUNT = 2;
    localparam int unsigned TPP_MAX    = 3;

    // Ticks per pixel for a mode index.
    function automatic int unsigned ticks_per_pixel(input int unsigned mode_idx);
        return (mode_idx == 0) ? 2 : 3;
    endfunction

endpackage

// File: rtl/lcd_timing_cfg.sv
// Holds the mode of the frame in progress and gives the horizontal limits
// for that mode. Limits for both modes are built by a generate loop and one
// set is selected. Assumes frame_end_i is high only on the last enabled tick
// of a frame.
module lcd_timing_cfg
    import lcd_sync_pkg::*;
#(
    parameter int unsigned H_TOTAL_PIX = 336,
    parameter int unsigned HS_PIX      = 2,
    parameter int unsigned HSTART_PIX  = 7,
    parameter int unsigned H_ACT_PIX   = 320,
    parameter int unsigned DLY_RGB16   = 3,
    parameter int unsigned DLY_RGB24   = 5,
    parameter int unsigned H_W         = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en_i,
    input  logic           mode_i,
    input  logic           frame_end_i,
    output logic [H_W-1:0] line_last_o,
    output logic [H_W-1:0] hs_end_o,
    output logic [H_W-1:0] de_first_o,
    output logic [H_W-1:0] de_stop_o
);

    pix_mode_e      mode_q;
    logic [H_W-1:0] last_tab  [MODE_COUNT];
    logic [H_W-1:0] hsend_tab [MODE_COUNT];
    logic [H_W-1:0] first_tab [MODE_COUNT];
    logic [H_W-1:0] stop_tab  [MODE_COUNT];

    // Per-mode constant limits.
    for (genvar m = 0; m < MODE_COUNT; m++) begin : g_mode
        localparam int unsigned TPP  = ticks_per_pixel(m);
        localparam int unsigned DLY  = (m == 0) ? DLY_RGB16 : DLY_RGB24;
        localparam int unsigned FRST = HSTART_PIX * TPP + DLY;
        assign last_tab[m]  = H_W'(H_TOTAL_PIX * TPP - 1);
        assign hsend_tab[m] = H_W'(HS_PIX * TPP);
        assign first_tab[m] = H_W'(FRST);
        assign stop_tab[m]  = H_W'(FRST + H_ACT_PIX * TPP);
    end

    // Mode register: follows the input while idle, and loads at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            mode_q <= pix_mode_e'(mode_i);
        end else if (frame_end_i) begin
            mode_q <= pix_mode_e'(mode_i);
        end
    end

    // Select the limits of the frame in progress.
    always_comb begin
        line_last_o = last_tab[int'(mode_q)];
        hs_end_o    = hsend_tab[int'(mode_q)];
        de_first_o  = first_tab[int'(mode_q)];
        de_stop_o   = stop_tab[int'(mode_q)];
    end

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !frame_end_i) |=> $stable(mode_q)); // R9

endmodule

// File: rtl/lcd_tick_counter.sv
// Raster position counters: a tick counter within the line and a line
// counter within the frame. Both are held at zero while idle. Assumes
// line_last_i stays constant within a frame.
module lcd_tick_counter #(
    parameter int unsigned V_TOTAL = 244,
    parameter int unsigned H_W     = 10,
    parameter int unsigned V_W     = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en_i,
    input  logic [H_W-1:0] line_last_i,
    output logic [H_W-1:0] tick_o,
    output logic [V_W-1:0] line_o,
    output logic           frame_end_o
);

    localparam logic [V_W-1:0] LINE_LAST = V_W'(V_TOTAL - 1);

    logic line_end;

    assign line_end    = en_i && (tick_o == line_last_i);
    assign frame_end_o = line_end && (line_o == LINE_LAST);

    // Tick counter: counts the ticks of a line, then wraps.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            tick_o <= '0;
        end else if (line_end) begin
            tick_o <= '0;
        end else begin
            tick_o <= tick_o + 1'b1;
        end
    end

    // Line counter: advances at each line end and wraps at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            line_o <= '0;
        end else if (frame_end_o) begin
            line_o <= '0;
        end else if (line_end) begin
            line_o <= line_o + 1'b1;
        end
    end

    AST_H_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        line_end |=> (tick_o == '0)); // R3
    AST_V_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end_o |=> (line_o == '0)); // R4
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (tick_o == '0 && line_o == '0)); // R1
    AST_LINE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        line_o <= LINE_LAST); // R4

endmodule

// File: rtl/lcd_sync_decode.sv
// Turns the raster position into the line sync, the frame sync and the data
// enable. The outputs are combinational and forced inactive while idle.
// Assumes de_first_i < de_stop_i, and both lie within the line.
module lcd_sync_decode #(
    parameter int unsigned DE_V_FIRST = 2,
    parameter int unsigned DE_V_STOP  = 242,
    parameter int unsigned H_W        = 10,
    parameter int unsigned V_W        = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en_i,
    input  logic [H_W-1:0] tick_i,
    input  logic [V_W-1:0] line_i,
    input  logic [H_W-1:0] hs_end_i,
    input  logic [H_W-1:0] de_first_i,
    input  logic [H_W-1:0] de_stop_i,
    output logic           hs_n_o,
    output logic           vs_n_o,
    output logic           de_o
);

    logic run;
    logic in_hs;
    logic row_act;
    logic col_act;

    // Window decode gated by the run state.
    always_comb begin
        run     = rst_n && en_i;
        in_hs   = tick_i < hs_end_i;
        row_act = (line_i >= V_W'(DE_V_FIRST)) && (line_i < V_W'(DE_V_STOP));
        col_act = (tick_i >= de_first_i) && (tick_i < de_stop_i);
        hs_n_o  = !(run && in_hs);
        vs_n_o  = !(run && in_hs && (line_i == '0));
        de_o    = run && row_act && col_act;
    end

    AST_VS_INSIDE_HS: assert property (@(posedge clk) disable iff (!rst_n)
        !vs_n_o |-> !hs_n_o); // R6
    AST_DE_CLEAR_OF_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        de_o |-> (hs_n_o && vs_n_o)); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> (hs_n_o && vs_n_o && !de_o)); // R1

endmodule

// File: rtl/lcd_sync_gen.sv
// Top of the TFT sync generator for a byte-serial bus. It joins the mode and
// limit selector, the raster counters and the output decode. Every timing is
// in bus ticks. Assumes the active window fits inside the line in both modes.
module lcd_sync_gen #(
    parameter int unsigned H_ACT_PIX   = 320,
    parameter int unsigned H_TOTAL_PIX = 336,
    parameter int unsigned HS_PIX      = 2,
    parameter int unsigned HSTART_PIX  = 7,
    parameter int unsigned V_ACT       = 240,
    parameter int unsigned V_BLANK     = 4,
    parameter int unsigned DLY_RGB16   = 3,
    parameter int unsigned DLY_RGB24   = 5,
    parameter int unsigned H_W         = $clog2(H_TOTAL_PIX * lcd_sync_pkg::TPP_MAX + 1),
    parameter int unsigned V_W         = $clog2(V_ACT + V_BLANK)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en_i,
    input  logic           mode_i,
    output logic           hs_n_o,
    output logic           vs_n_o,
    output logic           de_o,
    output logic [V_W-1:0] line_o,
    output logic [H_W-1:0] tick_o
);

    localparam int unsigned V_TOTAL    = V_ACT + V_BLANK;
    localparam int unsigned DE_V_FIRST = V_BLANK / 2;
    localparam int unsigned DE_V_STOP  = DE_V_FIRST + V_ACT;

    logic [H_W-1:0] line_last;
    logic [H_W-1:0] hs_end;
    logic [H_W-1:0] de_first;
    logic [H_W-1:0] de_stop;
    logic           frame_end;

    lcd_timing_cfg #(
        .H_TOTAL_PIX(H_TOTAL_PIX), .HS_PIX(HS_PIX), .HSTART_PIX(HSTART_PIX),
        .H_ACT_PIX(H_ACT_PIX), .DLY_RGB16(DLY_RGB16), .DLY_RGB24(DLY_RGB24),
        .H_W(H_W)
    ) cfg_i (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .mode_i(mode_i),
        .frame_end_i(frame_end), .line_last_o(line_last), .hs_end_o(hs_end),
        .de_first_o(de_first), .de_stop_o(de_stop)
    );

    lcd_tick_counter #(
        .V_TOTAL(V_TOTAL), .H_W(H_W), .V_W(V_W)
    ) cnt_i (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .line_last_i(line_last),
        .tick_o(tick_o), .line_o(line_o), .frame_end_o(frame_end)
    );

    lcd_sync_decode #(
        .DE_V_FIRST(DE_V_FIRST), .DE_V_STOP(DE_V_STOP), .H_W(H_W), .V_W(V_W)
    ) dec_i (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .tick_i(tick_o), .line_i(line_o),
        .hs_end_i(hs_end), .de_first_i(de_first), .de_stop_i(de_stop),
        .hs_n_o(hs_n_o), .vs_n_o(vs_n_o), .de_o(de_o)
    );

    AST_FIRST_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !$past(en_i)) |-> (tick_o == '0 && line_o == '0)); // R1

endmodule

// File: tb/lcd_sync_gen_tb_top.sv
// Scoreboard bench: the driver applies inputs at the falling edge and queues
// the outputs expected for that cycle. The monitor compares shortly after.
module lcd_sync_gen_tb_top;

    localparam int unsigned H_ACT   = 8;
    localparam int unsigned H_TOT   = 14;
    localparam int unsigned HS_P    = 2;
    localparam int unsigned HST_P   = 3;
    localparam int unsigned V_ACT_L = 4;
    localparam int unsigned V_BLK   = 4;
    localparam int unsigned D16     = 3;
    localparam int unsigned D24     = 5;
    localparam int unsigned HW      = $clog2(H_TOT * 3 + 1);
    localparam int unsigned VW      = $clog2(V_ACT_L + V_BLK);
    localparam int unsigned VT      = V_ACT_L + V_BLK;

    typedef struct packed {
        logic [HW-1:0] tick;
        logic [VW-1:0] line;
        logic          hs;
        logic          vs;
        logic          de;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          en_i;
    logic          mode_i;
    logic          hs_n_o;
    logic          vs_n_o;
    logic          de_o;
    logic [VW-1:0] line_o;
    logic [HW-1:0] tick_o;

    int    checks = 0;
    int    errors = 0;
    exp_t  exp_q[$];
    string tag_q[$];
    int    m_h = 0;
    int    m_v = 0;
    int    m_mode = 0;

    always #5 clk = ~clk;

    lcd_sync_gen #(
        .H_ACT_PIX(H_ACT), .H_TOTAL_PIX(H_TOT), .HS_PIX(HS_P), .HSTART_PIX(HST_P),
        .V_ACT(V_ACT_L), .V_BLANK(V_BLK), .DLY_RGB16(D16), .DLY_RGB24(D24)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .mode_i(mode_i),
        .hs_n_o(hs_n_o), .vs_n_o(vs_n_o), .de_o(de_o), .line_o(line_o), .tick_o(tick_o)
    );

    // Driver: one cycle of stimulus plus its expected outputs (R1..R9 model).
    task automatic step(input logic r, input logic e, input logic md, input string tag);
        exp_t x;
        int   tpp;
        int   first;
        logic run;
        @(negedge clk);
        rst_n  = r;
        en_i   = e;
        mode_i = md;
        tpp    = (m_mode == 0) ? 2 : 3;
        first  = HST_P * tpp + ((m_mode == 0) ? D16 : D24);
        run    = r && e;
        x.tick = HW'(m_h);
        x.line = VW'(m_v);
        x.hs   = !(run && m_h < HS_P * tpp);
        x.vs   = !(run && m_h < HS_P * tpp && m_v == 0);
        x.de   = run && m_v >= V_BLK / 2 && m_v < V_BLK / 2 + V_ACT_L
                 && m_h >= first && m_h < first + H_ACT * tpp;
        exp_q.push_back(x);
        tag_q.push_back(tag);
        if (!run) begin
            m_h = 0; m_v = 0; m_mode = int'(md);
        end else if (m_h == H_TOT * tpp - 1) begin
            m_h = 0;
            if (m_v == VT - 1) begin
                m_v = 0; m_mode = int'(md);
            end else begin
                m_v = m_v + 1;
            end
        end else begin
            m_h = m_h + 1;
        end
    endtask

    task automatic run_n(input int n, input logic r, input logic e, input logic md,
                         input string tag);
        for (int i = 0; i < n; i++) step(r, e, md, tag);
    endtask

    // Single field comparison with its requirement tag.
    task automatic cmp(input string req, input string tag, input string fld,
                       input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s [%s] %s actual %0d expected %0d at %0t",
                     req, tag, fld, act, expv, $time);
        end
    endtask

    // Monitor: pops the expected item and compares every output.
    always @(negedge clk) begin
        exp_t  x;
        string t;
        #2;
        if (exp_q.size() > 0) begin
            x = exp_q.pop_front();
            t = tag_q.pop_front();
            cmp("R3", t, "tick_o", int'(tick_o), int'(x.tick));
            cmp("R4", t, "line_o", int'(line_o), int'(x.line));
            cmp("R5", t, "hs_n_o", int'(hs_n_o), int'(x.hs));
            cmp("R6", t, "vs_n_o", int'(vs_n_o), int'(x.vs));
            if (int'(x.line) >= V_BLK / 2 && int'(x.line) < V_BLK / 2 + V_ACT_L)
                cmp("R7", t, "de_o", int'(de_o), int'(x.de));
            else
                cmp("R8", t, "de_o", int'(de_o), int'(x.de));
        end
    end

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; en_i = 1'b0; mode_i = 1'b0;
        @(posedge clk); @(posedge clk);
        run_n(3,   1'b0, 1'b0, 1'b0, "R1 reset");
        run_n(2,   1'b1, 1'b0, 1'b0, "R1 idle");
        run_n(230, 1'b1, 1'b1, 1'b0, "R2 R3 rgb16");
        run_n(40,  1'b1, 1'b1, 1'b1, "R9 switch mid frame");
        run_n(600, 1'b1, 1'b1, 1'b1, "R2 rgb24");
        run_n(3,   1'b1, 1'b0, 1'b0, "R1 disable");
        run_n(60,  1'b1, 1'b1, 1'b0, "R1 restart");
        run_n(2,   1'b0, 1'b1, 1'b0, "R1 reset while enabled");
        run_n(300, 1'b1, 1'b1, 1'b1, "R4 R8 frame after reset");
        @(negedge clk); @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule